// File: doc/BRIEF.md
# Error-Tolerant Framing Code Detector

This block sits at the front of a serial data acquisition path. On every bit clock it moves one serial bit into an eight-bit history and compares that history with a programmable framing code. When at least seven of the eight positions agree, the validation window is open, the detector is enabled and no line is already running, the block starts a new line. It raises a one-cycle start pulse, restarts its divide-by-eight character counter from that point, and from then on delivers every eighth bit as a parallel byte with a one-cycle strobe.

A line stays open until the end-of-line input closes it or reset is applied. While a line is open, further framing codes in the data are treated as payload. The framing code can be rewritten only while the detector is enabled and idle. Prefix decoding and packet length counting are done by logic downstream of this block.

Top module: `frame_code_detector`

## Requirements
- R1: A synchronous active-high reset clears line_start, char_strobe and char_byte to 0, leaves the detector idle, and sets the framing code to the parameter RESET_CODE (default 8'hE7).
- R2: Bits enter the history least-significant first. In each delivered byte, bit 0 holds the earliest of its eight bits and bit 7 the latest.
- R3: The comparison counts a match when at least MIN_AGREE (default 7) of the 8 history bits equal the corresponding framing-code bits. An exact code and a code with one flipped bit both start a line. A code with two flipped bits does not.
- R4: A match only counts when window is high on the clock edge at which it is taken, which is the edge after the last framing-code bit was shifted in.
- R5: line_start is high for exactly one cycle. It appears in the cycle after the match, and it is also the cycle in which the first payload bit has been taken.
- R6: After a line starts, char_strobe pulses for one cycle after every eighth payload bit. The first pulse comes 7 cycles after line_start, and char_byte is updated together with it.
- R7: While a line is open, framing codes in the data stream produce no line_start, and the character alignment does not change.
- R8: end_of_line high during an open line returns the detector to idle at the next edge, with no strobe on that edge. A later framing code then starts a new line.
- R9: A code_load writes code_in into the framing-code register only when enable is high and no line is open. Otherwise the stored code is unchanged.
- R10: With enable low, no framing code starts a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Permits line starts and framing-code writes |
| serial_in | input | 1 | Serial data bit taken on each clock edge |
| window | input | 1 | Validation window; a match counts only while high |
| code_in | input | 8 | New framing code value |
| code_load | input | 1 | Request to write code_in into the framing-code register |
| end_of_line | input | 1 | Closes an open line |
| line_start | output | 1 | One-cycle pulse marking the start of a line |
| char_strobe | output | 1 | One-cycle pulse marking a new char_byte |
| char_byte | output | 8 | Last assembled payload character |

## Verification
Directed frames use the exact code, the code with one bit flipped and the code with two bits flipped. These separate the agreement threshold from an exact compare and from an off-by-one threshold. The same frame is also sent with the window low, with enable low, during an open line, after end_of_line, and after code writes that were permitted or refused, so the test shows which gating condition blocks a start. A long stretch of random bits, windows, loads and line ends with framing codes injected at random mismatch levels is compared cycle by cycle with a bench model. This shows whether start timing, strobe phase and byte bit order stay correct when matches land at arbitrary bit phases.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [0:0] {
        LINE_IDLE = 1'b0,
        LINE_BUSY = 1'b1
    } line_state_e;

    typedef struct packed {
        logic line_start;
        logic char_strobe;
    } fcd_evt_t;

    function automatic int unsigned count_ones(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/fcd_shifter.sv
module fcd_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_in,
    output logic [W-1:0] hist_q,
    output logic [W-1:0] hist_next
);
    assign hist_next = {bit_in, hist_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_next;
        end
    end
endmodule

// File: rtl/fcd_code_reg.sv
module fcd_code_reg #(
    parameter int unsigned W          = 8,
    parameter logic [W-1:0] RESET_CODE = 8'hE7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         write_ok,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
        end else if (write_ok) begin
            code_q <= code_in;
        end
    end
endmodule

// File: rtl/fcd_matcher.sv
module fcd_matcher #(
    parameter int unsigned W         = 8,
    parameter int unsigned MIN_AGREE = 7
) (
    input  logic [W-1:0] hist,
    input  logic [W-1:0] code,
    output logic         hit
);
    import fcd_pkg::*;

    logic [W-1:0] agree;
    logic [31:0]  agree_ext;
    int unsigned  n_agree;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign agree[g] = ~(hist[g] ^ code[g]);
    end

    assign agree_ext = 32'(agree);
    assign n_agree   = count_ones(agree_ext);
    assign hit       = (n_agree >= MIN_AGREE);
endmodule

// File: rtl/fcd_char_timer.sv
module fcd_char_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         window,
    input  logic         hit,
    input  logic         end_of_line,
    input  logic [W-1:0] hist_next,
    output logic         line_start,
    output logic         char_strobe,
    output logic [W-1:0] char_byte,
    output logic         line_active
);
    import fcd_pkg::*;

    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT  = CW'(W - 1);
    localparam logic [CW-1:0] FIRST_BIT = CW'(1);

    line_state_e   state_q;
    logic [CW-1:0] bit_cnt_q;
    fcd_evt_t      evt_q;
    logic          start_ok;

    assign start_ok    = hit & window & enable & (state_q == LINE_IDLE);
    assign line_active = (state_q == LINE_BUSY);
    assign line_start  = evt_q.line_start;
    assign char_strobe = evt_q.char_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= LINE_IDLE;
            bit_cnt_q <= '0;
            evt_q     <= '0;
            char_byte <= '0;
        end else begin
            evt_q.line_start  <= start_ok;
            evt_q.char_strobe <= 1'b0;
            if (state_q == LINE_BUSY && end_of_line) begin
                state_q   <= LINE_IDLE;
                bit_cnt_q <= '0;
            end else if (start_ok) begin
                state_q   <= LINE_BUSY;
                bit_cnt_q <= FIRST_BIT;
            end else if (state_q == LINE_BUSY) begin
                if (bit_cnt_q == LAST_BIT) begin
                    evt_q.char_strobe <= 1'b1;
                    char_byte         <= hist_next;
                    bit_cnt_q         <= '0;
                end else begin
                    bit_cnt_q <= bit_cnt_q + FIRST_BIT;
                end
            end
        end
    end
endmodule

// File: rtl/frame_code_detector.sv
module frame_code_detector #(
    parameter int unsigned W          = 8,
    parameter int unsigned MIN_AGREE  = 7,
    parameter logic [W-1:0] RESET_CODE = 8'hE7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         serial_in,
    input  logic         window,
    input  logic [W-1:0] code_in,
    input  logic         code_load,
    input  logic         end_of_line,
    output logic         line_start,
    output logic         char_strobe,
    output logic [W-1:0] char_byte
);
    logic [W-1:0] hist_q;
    logic [W-1:0] hist_next;
    logic [W-1:0] code_q;
    logic         hit;
    logic         line_active;
    logic         code_write_ok;

    assign code_write_ok = code_load & enable & ~line_active;

    fcd_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (serial_in),
        .hist_q    (hist_q),
        .hist_next (hist_next)
    );

    fcd_code_reg #(.W(W), .RESET_CODE(RESET_CODE)) u_code (
        .clk      (clk),
        .rst      (rst),
        .write_ok (code_write_ok),
        .code_in  (code_in),
        .code_q   (code_q)
    );

    fcd_matcher #(.W(W), .MIN_AGREE(MIN_AGREE)) u_match (
        .hist (hist_q),
        .code (code_q),
        .hit  (hit)
    );

    fcd_char_timer #(.W(W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .window      (window),
        .hit         (hit),
        .end_of_line (end_of_line),
        .hist_next   (hist_next),
        .line_start  (line_start),
        .char_strobe (char_strobe),
        .char_byte   (char_byte),
        .line_active (line_active)
    );
endmodule

// File: rtl/frame_code_detector_chk.sv
module frame_code_detector_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         enable,
    input logic         window,
    input logic         code_load,
    input logic         end_of_line,
    input logic         line_start,
    input logic         char_strobe,
    input logic         line_active,
    input logic [W-1:0] code_q
);
    p_start_single_r5: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

    p_start_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        line_start |-> $past(window));

    p_start_enabled_r10: assert property (@(posedge clk) disable iff (rst)
        line_start |-> $past(enable));

    p_start_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        line_start |-> !$past(line_active));

    p_start_opens_line_r5: assert property (@(posedge clk) disable iff (rst)
        line_start |-> line_active);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        char_strobe |=> !char_strobe);

    p_strobe_in_line_r6: assert property (@(posedge clk) disable iff (rst)
        char_strobe |-> $past(line_active) && !$past(end_of_line));

    p_eol_closes_r8: assert property (@(posedge clk) disable iff (rst)
        (end_of_line && line_active) |=> !line_active);

    p_code_guard_r9: assert property (@(posedge clk) disable iff (rst)
        (code_load && (!enable || line_active)) |=> $stable(code_q));
endmodule

bind frame_code_detector frame_code_detector_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .window      (window),
    .code_load   (code_load),
    .end_of_line (end_of_line),
    .line_start  (line_start),
    .char_strobe (char_strobe),
    .line_active (line_active),
    .code_q      (code_q)
);

// File: tb/frame_code_detector_tb.sv
`timescale 1ns/1ps
module frame_code_detector_tb;
    localparam int MAX_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       serial_in = 1'b0;
    logic       window = 1'b0;
    logic [7:0] code_in = 8'h00;
    logic       code_load = 1'b0;
    logic       end_of_line = 1'b0;
    logic       line_start;
    logic       char_strobe;
    logic [7:0] char_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_hist;
    logic [7:0] m_code;
    logic       m_active;
    int         m_cnt;
    logic       e_ls;
    logic       e_cs;
    logic [7:0] e_byte;

    // directed observation
    int         ls_at;
    int         cs_at;
    logic [7:0] got_byte;

    always #2.5 clk = ~clk;

    frame_code_detector u_dut (
        .clk(clk), .rst(rst), .enable(enable), .serial_in(serial_in),
        .window(window), .code_in(code_in), .code_load(code_load),
        .end_of_line(end_of_line), .line_start(line_start),
        .char_strobe(char_strobe), .char_byte(char_byte)
    );

    function automatic int agree_cnt(input logic [7:0] a, input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) if (a[i] == b[i]) n++;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hist = 8'h00; m_code = 8'hE7; m_active = 1'b0; m_cnt = 0;
        e_ls = 1'b0; e_cs = 1'b0; e_byte = 8'h00;
    endtask

    task automatic model_edge(input logic b, input logic w, input logic eol,
                              input logic ld, input logic [7:0] cd, input logic en);
        logic hit;
        logic was_active;
        was_active = m_active;
        hit = en && w && !m_active && (agree_cnt(m_hist, m_code) >= 7);
        e_ls = hit;
        e_cs = 1'b0;
        if (eol && m_active) begin
            m_active = 1'b0; m_cnt = 0;
        end else if (hit) begin
            m_active = 1'b1; m_cnt = 1;
        end else if (m_active) begin
            if (m_cnt == 7) begin
                e_cs = 1'b1; e_byte = {b, m_hist[7:1]}; m_cnt = 0;
            end else m_cnt++;
        end
        if (ld && en && !was_active) m_code = cd;
        m_hist = {b, m_hist[7:1]};
    endtask

    task automatic step(input logic b, input logic w, input logic eol,
                        input logic ld, input logic [7:0] cd, input logic en);
        @(negedge clk);
        serial_in = b; window = w; end_of_line = eol;
        code_load = ld; code_in = cd; enable = en;
        @(posedge clk);
        model_edge(b, w, eol, ld, cd, en);
        #1;
        check(line_start === e_ls, "R5 line_start", int'(line_start), int'(e_ls));
        check(char_strobe === e_cs, "R6 char_strobe", int'(char_strobe), int'(e_cs));
        if (e_cs) check(char_byte === e_byte, "R2 char_byte", int'(char_byte), int'(e_byte));
    endtask

    // code bits with window low, then data bits; window (w) only on the edge
    // right after the last code bit
    task automatic frame(input logic [7:0] pat, input logic w, input logic en,
                         input logic [7:0] data);
        ls_at = -1; cs_at = -1; got_byte = 8'h00;
        for (int i = 0; i < 8; i++) step(pat[i], 1'b0, 1'b0, 1'b0, 8'h00, en);
        for (int i = 0; i < 8; i++) begin
            step(data[i], (i == 0) ? w : 1'b0, 1'b0, 1'b0, 8'h00, en);
            if (line_start === 1'b1 && ls_at < 0) ls_at = i;
            if (char_strobe === 1'b1 && cs_at < 0) begin cs_at = i; got_byte = char_byte; end
        end
    endtask

    task automatic close_line();
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
    endtask

    initial begin
        #(MAX_CYCLES * 5.0);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state at the ports
        check(line_start === 1'b0, "R1 line_start", int'(line_start), 0);
        check(char_strobe === 1'b0, "R1 char_strobe", int'(char_strobe), 0);
        check(char_byte === 8'h00, "R1 char_byte", int'(char_byte), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R3: default code, exact; R2 / R5 / R6 timing and bit order
        frame(8'hE7, 1'b1, 1'b1, 8'hA5);
        check(ls_at == 0, "R1 R3 R5 start with default code", ls_at, 0);
        check(cs_at == 7, "R6 first strobe phase", cs_at, 7);
        check(got_byte == 8'hA5, "R2 first byte order", int'(got_byte), 8'hA5);
        close_line();

        // R3: one flipped bit still starts
        frame(8'hE7 ^ 8'h08, 1'b1, 1'b1, 8'h3C);
        check(ls_at == 0, "R3 one bit error", ls_at, 0);
        close_line();

        // R3: two flipped bits do not start
        frame(8'hE7 ^ 8'h09, 1'b1, 1'b1, 8'h00);
        check(ls_at < 0, "R3 two bit errors", ls_at, -1);
        check(cs_at < 0, "R3 no strobe when idle", cs_at, -1);

        // R4: window low
        frame(8'hE7, 1'b0, 1'b1, 8'h00);
        check(ls_at < 0, "R4 window closed", ls_at, -1);

        // R10: enable low
        frame(8'hE7, 1'b1, 1'b0, 8'h00);
        check(ls_at < 0, "R10 disabled", ls_at, -1);

        // R7: code inside an open line is payload
        frame(8'hE7, 1'b1, 1'b1, 8'h11);
        check(ls_at == 0, "R7 line opened", ls_at, 0);
        frame(8'hE7, 1'b1, 1'b1, 8'h22);
        check(ls_at < 0, "R7 no restart while busy", ls_at, -1);
        check(cs_at == 7, "R7 alignment kept", cs_at, 7);
        check(got_byte == 8'h22, "R7 payload byte", int'(got_byte), 8'h22);

        // R8: end of line then restart
        close_line();
        frame(8'hE7, 1'b1, 1'b1, 8'h5A);
        check(ls_at == 0, "R8 restart after end_of_line", ls_at, 0);

        // R9: load while busy is refused
        step(1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1);
        close_line();
        frame(8'h3C, 1'b1, 1'b1, 8'h00);
        check(ls_at < 0, "R9 busy load refused", ls_at, -1);
        frame(8'hE7, 1'b1, 1'b1, 8'h00);
        check(ls_at == 0, "R9 old code kept", ls_at, 0);
        close_line();

        // R9: load while idle and enabled
        step(1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1);
        frame(8'h3C, 1'b1, 1'b1, 8'hC3);
        check(ls_at == 0, "R9 idle load taken", ls_at, 0);
        check(got_byte == 8'hC3, "R2 byte after new code", int'(got_byte), 8'hC3);
        close_line();

        // R9: load while disabled refused
        step(1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0);
        frame(8'h5A, 1'b1, 1'b1, 8'h00);
        check(ls_at < 0, "R9 disabled load refused", ls_at, -1);

        // random phase, checked cycle by cycle against the model
        begin
            int inj_left = 0;
            logic [7:0] inj = 8'h00;
            for (int n = 0; n < 6000; n++) begin
                logic b, w, eol, ld, en;
                logic [7:0] cd;
                if (inj_left == 0 && ($urandom % 40) == 0) begin
                    int flips = $urandom % 3;
                    inj = m_code;
                    for (int f = 0; f < flips; f++) inj[$urandom % 8] ^= 1'b1;
                    inj_left = 8;
                end
                if (inj_left > 0) begin
                    b = inj[8 - inj_left];
                    inj_left--;
                end else b = 1'($urandom);
                w   = (($urandom % 4) != 0);
                eol = (($urandom % 30) == 0);
                ld  = (($urandom % 60) == 0);
                en  = (($urandom % 12) != 0);
                cd  = ((($urandom % 2) == 0) ? 8'hE7 : 8'($urandom));
                step(b, w, eol, ld, cd, en);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule